// File: doc/BRIEF.md
# RGB Panel Raster Timing Generator

This block produces the raster timing for a parallel RGB display panel: horizontal sync, vertical sync, data enable and a pixel clock strobe, together with the active-area pixel coordinates that a downstream fetch stage needs. Every line runs through four phases in a fixed order: sync pulse, back porch, active pixels, front porch. The frame runs through the same four phases counted in lines. Each phase length is programmed as its value minus one. All configuration inputs are expected to stay stable while the raster is running.

The pixel rate comes from the source clock. It is either taken directly or divided by a programmable ratio of at most 255. Each of the four panel outputs has its own polarity-invert bit. A one-cycle frame interrupt marks the entry into a selectable vertical phase. Raising the enable starts a frame at once. Lowering it lets the current frame complete, and after that all outputs rest at their inactive levels.

Top module: `lcd_timing_gen`

## Requirements
- R1: Each line consists of `hsync_m1+1` sync pixels, then `hback_m1+1` back-porch pixels, then `hact_m1+1` active pixels, then `hfront_m1+1` front-porch pixels. The nominal horizontal sync is high exactly during the sync pixels.
- R2: Each frame consists of `vsync_m1+1` sync lines, then `vback_m1+1` back-porch lines, then `vact_m1+1` active lines, then `vfront_m1+1` front-porch lines. The nominal vertical sync is high for whole lines exactly during the sync lines.
- R3: The nominal data enable is high only when the pixel is in the active phase and the line is in the active phase. `pix_x` gives the pixel index within the horizontal active phase and is 0 outside it. `pix_y` gives the line index within the vertical active phase and is 0 outside it.
- R4: Each output is its nominal (active-high) value XOR its own invert bit. The invert bits are `inv_hsync`, `inv_vsync`, `inv_de` and `inv_pclk`.
- R5: With `div_on`=1, each pixel lasts `div_m1+1` source cycles, and the nominal `pclk` strobe is high on the last source cycle of each pixel. With `div_on`=0, every source cycle is one pixel, the nominal strobe is constantly high while running, and `div_m1` has no effect.
- R6: A `div_m1` value of 255 gives a ratio of 255, the same as 254, so the ratio never exceeds 255.
- R7: The encoding of `irq_sel` is: 0 selects the first cycle of the vertical front porch, 1 the first cycle of the vertical sync (frame start), 2 the first cycle of the vertical active region, and 3 disables the interrupt. `frame_irq` is high for exactly one source cycle at the selected point.
- R8: When `enable` is sampled high while idle, the first sync pixel of line 0 is presented in the very next cycle.
- R9: When `enable` is low at the last source cycle of a frame, the raster stops and every output rests at its inactive level. When `enable` is high at that point, the next frame follows without a gap.
- R10: After reset the block is idle, `frame_irq` is low and all outputs are at their inactive levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run request; a low level stops the raster at the end of the frame |
| div_on | input | 1 | Use the divider (1) or the source clock directly (0) |
| div_m1 | input | DIV_W | Divide ratio minus one |
| hsync_m1 | input | H_W | Horizontal sync width minus one |
| hback_m1 | input | H_W | Horizontal back porch minus one |
| hact_m1 | input | H_W | Active pixels per line minus one |
| hfront_m1 | input | H_W | Horizontal front porch minus one |
| vsync_m1 | input | V_W | Vertical sync lines minus one |
| vback_m1 | input | V_W | Vertical back porch lines minus one |
| vact_m1 | input | V_W | Active lines minus one |
| vfront_m1 | input | V_W | Vertical front porch lines minus one |
| inv_hsync | input | 1 | Invert horizontal sync |
| inv_vsync | input | 1 | Invert vertical sync |
| inv_de | input | 1 | Invert data enable |
| inv_pclk | input | 1 | Invert pixel clock strobe |
| irq_sel | input | 2 | Interrupt point select |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pclk | output | 1 | Pixel clock strobe |
| pix_x | output | H_W | Active pixel index |
| pix_y | output | V_W | Active line index |
| frame_irq | output | 1 | One-cycle frame interrupt |

## Verification
The raster is tried under four contrasting configurations. The first uses the bypass path with a nonzero divider value and two back-to-back frames, which tests seamless frame chaining and shows that the field is ignored. The second divides by three with every output inverted, which separates pixel stretching and polarity handling from the phase order. The third uses the maximum divider field with one-unit phases, which exposes the ratio cap and the shortest possible phases. The fourth divides by one with the divider engaged, where the strobe must look the same as in bypass, and selects the active-region interrupt. In each configuration every source cycle is compared against an expected stream, so a shifted phase boundary, a wrong interrupt point or a late stop shows up in the exact cycle where it occurs.

// File: rtl/lcdt_pkg.sv
// Shared types for the raster timing generator.
// Assumes the phase order sync, back porch, active, front porch on both axes.
package lcdt_pkg;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } phase_t;

    // Interrupt point select codes.
    localparam logic [1:0] IRQ_AT_FRONT  = 2'd0;
    localparam logic [1:0] IRQ_AT_SYNC   = 2'd1;
    localparam logic [1:0] IRQ_AT_ACTIVE = 2'd2;
    localparam logic [1:0] IRQ_OFF       = 2'd3;

    // Phase that follows p in the fixed order.
    function automatic phase_t phase_after(phase_t p);
        case (p)
            PH_SYNC:   return PH_BACK;
            PH_BACK:   return PH_ACTIVE;
            PH_ACTIVE: return PH_FRONT;
            default:   return PH_SYNC;
        endcase
    endfunction

    // Vertical phase whose entry raises the interrupt for a select code.
    function automatic phase_t irq_phase(logic [1:0] sel);
        case (sel)
            IRQ_AT_FRONT:  return PH_FRONT;
            IRQ_AT_ACTIVE: return PH_ACTIVE;
            default:       return PH_SYNC;
        endcase
    endfunction

endpackage

// File: rtl/lcdt_pixdiv.sv
// Pixel strobe generator: emits one tick per pixel while running.
// Assumes div_m1 is stable while run is high; the all-ones code is capped
// so that the ratio never exceeds 2**DIV_W - 1.
module lcdt_pixdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             div_on,
    input  logic [DIV_W-1:0] div_m1,
    output logic             tick
);
    localparam logic [DIV_W-1:0] CODE_MAX = {DIV_W{1'b1}};
    localparam logic [DIV_W-1:0] CODE_CAP = CODE_MAX - 1'b1;

    logic [DIV_W-1:0] ratio_m1;
    logic [DIV_W-1:0] phase_cnt;

    // Clamp the programmed ratio.
    always_comb ratio_m1 = (div_m1 == CODE_MAX) ? CODE_CAP : div_m1;

    // Tick on the last source cycle of each pixel, or every cycle in bypass.
    always_comb tick = run && (!div_on || (phase_cnt == ratio_m1));

    // Count source cycles within the current pixel.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !div_on)
            phase_cnt <= '0;
        else if (phase_cnt == ratio_m1)
            phase_cnt <= '0;
        else
            phase_cnt <= phase_cnt + 1'b1;
    end

    // The cycle counter never reaches the all-ones code (ratio cap).
    assert_ratio_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        phase_cnt != CODE_MAX);

endmodule

// File: rtl/lcdt_axis.sv
// One raster axis: steps through sync, back porch, active, front porch,
// with each phase length given as length minus one. Parked at the start
// of sync while hold is high. Assumes len_m1 is stable while stepping.
module lcdt_axis import lcdt_pkg::*; #(
    parameter int W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              step,
    input  logic [3:0][W-1:0] len_m1,
    output phase_t            phase,
    output logic [W-1:0]      cnt,
    output logic              at_end
);
    logic [W-1:0] cur_len;

    // Length of the phase in progress.
    always_comb cur_len = len_m1[phase];

    // Last unit of the last phase ends the axis period.
    always_comb at_end = (phase == PH_FRONT) && (cnt == cur_len);

    // Advance the position one unit per step.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            phase <= PH_SYNC;
            cnt   <= '0;
        end else if (step) begin
            if (cnt == cur_len) begin
                phase <= phase_after(phase);
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // The count stays within the programmed phase length.
    assert_cnt_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= len_m1[phase]);

    // Without a step the position does not move.
    assert_hold_without_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !hold) |=> ($stable(cnt) && $stable(phase)));

endmodule

// File: rtl/lcd_timing_gen.sv
// RGB panel raster timing generator: one pixel divider, a horizontal and a
// vertical axis, polarity stage and frame interrupt. Assumes configuration
// inputs change only while the raster is stopped.
module lcd_timing_gen import lcdt_pkg::*; #(
    parameter int H_W   = 11,
    parameter int V_W   = 11,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             div_on,
    input  logic [DIV_W-1:0] div_m1,
    input  logic [H_W-1:0]   hsync_m1,
    input  logic [H_W-1:0]   hback_m1,
    input  logic [H_W-1:0]   hact_m1,
    input  logic [H_W-1:0]   hfront_m1,
    input  logic [V_W-1:0]   vsync_m1,
    input  logic [V_W-1:0]   vback_m1,
    input  logic [V_W-1:0]   vact_m1,
    input  logic [V_W-1:0]   vfront_m1,
    input  logic             inv_hsync,
    input  logic             inv_vsync,
    input  logic             inv_de,
    input  logic             inv_pclk,
    input  logic [1:0]       irq_sel,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             pclk,
    output logic [H_W-1:0]   pix_x,
    output logic [V_W-1:0]   pix_y,
    output logic             frame_irq
);
    logic running, running_d;
    logic tick, h_end, v_end, line_end, frame_done;
    phase_t h_ph, v_ph, v_ph_d;
    logic [H_W-1:0] h_cnt;
    logic [V_W-1:0] v_cnt;
    logic [3:0][H_W-1:0] h_len;
    logic [3:0][V_W-1:0] v_len;
    logic hs_n, vs_n, de_n, irq_n;

    // Phase lengths indexed by phase code.
    always_comb begin
        h_len = {hfront_m1, hact_m1, hback_m1, hsync_m1};
        v_len = {vfront_m1, vact_m1, vback_m1, vsync_m1};
    end

    lcdt_pixdiv #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (running),
        .div_on (div_on),
        .div_m1 (div_m1),
        .tick   (tick)
    );

    lcdt_axis #(.W(H_W)) u_hax (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (!running),
        .step   (tick),
        .len_m1 (h_len),
        .phase  (h_ph),
        .cnt    (h_cnt),
        .at_end (h_end)
    );

    // Line and frame boundaries.
    always_comb begin
        line_end   = tick && h_end;
        frame_done = line_end && v_end;
    end

    lcdt_axis #(.W(V_W)) u_vax (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (!running),
        .step   (line_end),
        .len_m1 (v_len),
        .phase  (v_ph),
        .cnt    (v_cnt),
        .at_end (v_end)
    );

    // Start on enable, stop only at a frame boundary with enable low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            running <= 1'b0;
        else if (!running && enable)
            running <= 1'b1;
        else if (frame_done && !enable)
            running <= 1'b0;
    end

    // Remember last cycle's vertical phase and run state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_d <= 1'b0;
            v_ph_d    <= PH_SYNC;
        end else begin
            running_d <= running;
            v_ph_d    <= v_ph;
        end
    end

    // Nominal (active-high) panel signals.
    always_comb begin
        hs_n  = running && (h_ph == PH_SYNC);
        vs_n  = running && (v_ph == PH_SYNC);
        de_n  = running && (h_ph == PH_ACTIVE) && (v_ph == PH_ACTIVE);
        irq_n = running && (irq_sel != IRQ_OFF) && (v_ph == irq_phase(irq_sel))
                && (!running_d || (v_ph != v_ph_d));
    end

    // Polarity stage and coordinates.
    always_comb begin
        hsync     = hs_n ^ inv_hsync;
        vsync     = vs_n ^ inv_vsync;
        de        = de_n ^ inv_de;
        pclk      = tick ^ inv_pclk;
        frame_irq = irq_n;
        pix_x     = (running && (h_ph == PH_ACTIVE)) ? h_cnt : '0;
        pix_y     = (running && (v_ph == PH_ACTIVE)) ? v_cnt : '0;
    end

    // The interrupt is a single-cycle pulse.
    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n |=> !irq_n);

    // Within the active region x advances by one per pixel.
    assert_x_advances_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && (h_ph == PH_ACTIVE) && (h_cnt != hact_m1))
        |=> (pix_x == H_W'($past(pix_x) + 1'b1)));

    // The raster never stops except at the end of a frame.
    assert_stop_at_frame_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !frame_done) |=> running);

    // While stopped both axes are parked at the start of sync.
    assert_idle_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (h_ph == PH_SYNC && h_cnt == '0 && v_ph == PH_SYNC && v_cnt == '0));

endmodule

// File: tb/lcd_timing_gen_bench.sv
// Scoreboard bench: a driver task queues the expected per-cycle outputs,
// a monitor pops and compares them against the design.
module lcd_timing_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int H_W = 11;
    localparam int V_W = 11;
    localparam int DIV_W = 8;

    typedef struct {
        bit    hs, vs, de, pc, irq;
        int    x, y;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic div_on = 1'b0;
    logic [DIV_W-1:0] div_m1 = '0;
    logic [H_W-1:0] hsync_m1 = '0, hback_m1 = '0, hact_m1 = '0, hfront_m1 = '0;
    logic [V_W-1:0] vsync_m1 = '0, vback_m1 = '0, vact_m1 = '0, vfront_m1 = '0;
    logic inv_hsync = 1'b0, inv_vsync = 1'b0, inv_de = 1'b0, inv_pclk = 1'b0;
    logic [1:0] irq_sel = 2'd0;
    logic hsync, vsync, de, pclk, frame_irq;
    logic [H_W-1:0] pix_x;
    logic [V_W-1:0] pix_y;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    exp_t q[$];

    lcd_timing_gen #(.H_W(H_W), .V_W(V_W), .DIV_W(DIV_W)) u_lcd_timing_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_on(div_on), .div_m1(div_m1),
        .hsync_m1(hsync_m1), .hback_m1(hback_m1), .hact_m1(hact_m1), .hfront_m1(hfront_m1),
        .vsync_m1(vsync_m1), .vback_m1(vback_m1), .vact_m1(vact_m1), .vfront_m1(vfront_m1),
        .inv_hsync(inv_hsync), .inv_vsync(inv_vsync), .inv_de(inv_de), .inv_pclk(inv_pclk),
        .irq_sel(irq_sel), .hsync(hsync), .vsync(vsync), .de(de), .pclk(pclk),
        .pix_x(pix_x), .pix_y(pix_y), .frame_irq(frame_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Locate unit i of an axis period in its phase.
    task automatic locate(int i, int len[4], output int ph, output int idx);
        int rem = i;
        ph = 0;
        while (rem >= len[ph]) begin
            rem -= len[ph];
            ph++;
        end
        idx = rem;
    endtask

    // Driver side: queue the expected stream for n frames and the idle tail.
    task automatic push_frames(int n, int hl[4], int vl[4], int ratio, bit bypass,
                               int sel, string pc_tag);
        int htot = hl[0] + hl[1] + hl[2] + hl[3];
        int vtot = vl[0] + vl[1] + vl[2] + vl[3];
        int npc = bypass ? 1 : ratio;
        int sel_ph = (sel == 0) ? 3 : (sel == 1) ? 0 : (sel == 2) ? 2 : -1;
        for (int f = 0; f < n; f++)
            for (int l = 0; l < vtot; l++) begin
                int vph, vidx;
                locate(l, vl, vph, vidx);
                for (int p = 0; p < htot; p++) begin
                    int hph, hidx;
                    locate(p, hl, hph, hidx);
                    for (int c = 0; c < npc; c++) begin
                        exp_t e;
                        e.hs  = (hph == 0);
                        e.vs  = (vph == 0);
                        e.de  = (hph == 2) && (vph == 2);
                        e.x   = (hph == 2) ? hidx : 0;
                        e.y   = (vph == 2) ? vidx : 0;
                        e.pc  = bypass ? 1'b1 : (c == npc - 1);
                        e.irq = (vph == sel_ph) && (vidx == 0) && (p == 0) && (c == 0);
                        e.tag = (f == 0 && l == 0 && p == 0 && c == 0) ? "R8" : pc_tag;
                        q.push_back(e);
                    end
                end
            end
        for (int k = 0; k < 4; k++) begin
            exp_t e;
            e.hs = 0; e.vs = 0; e.de = 0; e.pc = 0; e.irq = 0; e.x = 0; e.y = 0;
            e.tag = "R9";
            q.push_back(e);
        end
    endtask

    // Monitor side: compare each queued item at a falling edge.
    task automatic monitor();
        @(posedge clk);
        while (q.size() > 0) begin
            exp_t e;
            string t_pc, t_h, t_v, t_d, t_i;
            @(negedge clk);
            e = q.pop_front();
            t_pc = e.tag; t_h = "R1"; t_v = "R2"; t_d = "R3"; t_i = "R7";
            if (e.tag == "R8") t_h = "R8";
            if (e.tag == "R9") begin t_h = "R9"; t_v = "R9"; t_d = "R9"; t_i = "R9"; end
            chk(hsync == (e.hs ^ inv_hsync), t_h, "hsync", hsync, e.hs ^ inv_hsync);
            chk(vsync == (e.vs ^ inv_vsync), t_v, "vsync", vsync, e.vs ^ inv_vsync);
            chk(de == (e.de ^ inv_de), t_d, "de", de, e.de ^ inv_de);
            chk(int'(pix_x) == e.x, t_d, "pix_x", int'(pix_x), e.x);
            chk(int'(pix_y) == e.y, t_d, "pix_y", int'(pix_y), e.y);
            chk(pclk == (e.pc ^ inv_pclk), t_pc, "pclk", pclk, e.pc ^ inv_pclk);
            chk(frame_irq == e.irq, t_i, "frame_irq", frame_irq, e.irq);
        end
    endtask

    // Configure while idle, start, drop enable inside the last frame, check.
    task automatic run_case(int n, int hl[4], int vl[4], bit use_div, int dfield,
                            int sel, bit ih, bit iv, bit id, bit ip, string pc_tag);
        int ratio = (dfield == 255) ? 255 : dfield + 1;
        int fcyc = (hl[0] + hl[1] + hl[2] + hl[3]) * (vl[0] + vl[1] + vl[2] + vl[3])
                   * (use_div ? ratio : 1);
        @(negedge clk);
        hsync_m1 = H_W'(hl[0] - 1); hback_m1 = H_W'(hl[1] - 1);
        hact_m1  = H_W'(hl[2] - 1); hfront_m1 = H_W'(hl[3] - 1);
        vsync_m1 = V_W'(vl[0] - 1); vback_m1 = V_W'(vl[1] - 1);
        vact_m1  = V_W'(vl[2] - 1); vfront_m1 = V_W'(vl[3] - 1);
        div_on = use_div; div_m1 = DIV_W'(dfield); irq_sel = 2'(sel);
        inv_hsync = ih; inv_vsync = iv; inv_de = id; inv_pclk = ip;
        push_frames(n, hl, vl, ratio, !use_div, sel, pc_tag);
        @(negedge clk);
        enable = 1'b1;
        fork
            monitor();
            begin
                repeat ((n - 1) * fcyc + 3) @(posedge clk);
                @(negedge clk);
                enable = 1'b0;
            end
        join
    endtask

    initial begin
        int ha[4] = '{2, 3, 4, 2};
        int va[4] = '{1, 2, 3, 2};
        int hb[4] = '{1, 1, 5, 1};
        int vb[4] = '{2, 1, 2, 1};
        int hc[4] = '{1, 1, 1, 1};
        int vc[4] = '{1, 1, 1, 1};
        int hd[4] = '{3, 2, 3, 1};
        int vd[4] = '{1, 1, 2, 3};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle after reset
        chk(hsync == 0 && vsync == 0 && de == 0 && pclk == 0, "R10", "outputs",
            {hsync, vsync, de, pclk}, 0);
        chk(frame_irq == 0 && pix_x == 0 && pix_y == 0, "R10", "irq/xy",
            int'(frame_irq) + int'(pix_x) + int'(pix_y), 0);
        // R5: bypass ignores the divider field; two chained frames (R9); front porch irq
        run_case(2, ha, va, 1'b0, 5, 0, 0, 0, 0, 0, "R5");
        // R4: all polarities inverted, divide by 3, sync irq
        run_case(1, hb, vb, 1'b1, 2, 1, 1, 1, 1, 1, "R5");
        @(negedge clk);
        chk(hsync == 1 && vsync == 1 && de == 1 && pclk == 1, "R4", "inverted idle levels",
            {hsync, vsync, de, pclk}, 15);
        // R6: all-ones divider field gives ratio 255; interrupt off
        run_case(1, hc, vc, 1'b1, 255, 3, 1, 0, 0, 0, "R6");
        // R5: divider engaged at ratio 1; active irq; inverted data enable
        run_case(2, hd, vd, 1'b1, 0, 2, 0, 0, 1, 0, "R5");
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule